// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits behind a MAC receive path and records each arriving frame in a circular ring of receive buffer descriptors. Every descriptor has two 32-bit words. The address word holds the 4-byte-aligned buffer address in bits 31:2, a wrap marker in bit 1 and an ownership ("used") flag in bit 0. The status word holds a length in bits 13:0, a start-of-frame flag in bit 14 and an end-of-frame flag in bit 15. When the receive path hands over a frame length, the block works out how many fixed-size buffers the frame needs. It writes one descriptor per clock and moves its ring pointer forward after each write. After a descriptor that carries the wrap marker, the pointer goes back to the ring base.

The ring lives in a small descriptor store inside the block. A host-side port lets software set up the ring and recycle buffers. Software returns a buffer by clearing its used bit. The hardware never writes over a descriptor that is still owned by software. When it meets one, it discards the rest of the frame and pulses a buffer-not-available flag. Each time receive is switched on, the ring pointer is loaded from the base input.

Top module: `rxd_ring_writer`

## Requirements
- R1: When a descriptor is filled, bit 0 (used) of its address word becomes 1. Bits 31:2 (buffer address) and bit 1 (wrap) keep their previous values.
- R2: A filled status word carries end-of-frame in bit 15, start-of-frame in bit 14 and length in bits 13:0. Bits 31:16 keep the value software wrote there, for example 0xF000 from an initial 0xF0000000.
- R3: A frame of length L with L <= BUF_BYTES (1536 by default) fills exactly one descriptor, with both frame flags set and length L. This holds at L = BUF_BYTES.
- R4: A frame with L > BUF_BYTES fills ceil(L/BUF_BYTES) descriptors. Start-of-frame is set only in the first and end-of-frame only in the last. Every descriptor except the last has length BUF_BYTES. The last has length L, the total frame length.
- R5: After filling a descriptor, the pointer moves to the ring base if that descriptor's wrap bit is set. Otherwise it moves to the next index, modulo DEPTH.
- R6: If the descriptor about to be filled already has used = 1, then:
  - its contents are not changed;
  - the rest of the frame is discarded;
  - bna_o is high for exactly one cycle;
  - the pointer stays on that descriptor.
- R7: When rx_en rises, the pointer takes the value of ring_base. While rx_en is low, frm_ready is low, frames are not taken and the pointer does not move.
- R8: After a frame is accepted, the block fills one descriptor per clock. frm_ready stays low for exactly as many cycles as descriptors filled, or one cycle if the first descriptor is owned.
- R9: After reset, all descriptor words are zero, cur_idx is 0, bna_o is 0, and frm_ready is 0 while rx_en is low.
- R10: A host write updates the selected word, with host_sel 0 for the address word and 1 for the status word. host_rdata shows the selected word one cycle after host_idx/host_sel are applied. A descriptor whose used bit the host has cleared is filled again on the next visit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; a rising edge reloads the pointer |
| ring_base | input | IDXW | Index of the first descriptor of the ring |
| frm_valid | input | 1 | A received frame length is offered |
| frm_len | input | 14 | Total frame length in bytes |
| frm_ready | output | 1 | Block is idle and enabled; frame taken when frm_valid is also high |
| bna_o | output | 1 | One-cycle pulse: frame dropped on an owned descriptor |
| cur_idx | output | IDXW | Descriptor index the next fill will use |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | Word select: 0 address word, 1 status word |
| host_idx | input | IDXW | Descriptor index for host access |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle latency |

## Verification
The bench targets four cases:
- **Exact boundaries.** A frame of exactly one buffer must not spill into a second descriptor, and a frame one byte longer must take two. A design with an off-by-one in the split would either waste a descriptor or merge them.
- **Multi-buffer flags.** A three-buffer frame checks that start-of-frame appears only in the first descriptor, end-of-frame only in the last, and that the total length lands in the final descriptor. A design that wrote the piece length there would break host reassembly.
- **Wrap and ownership.** A wrap in the middle of memory must send the pointer back to the base. Owned descriptors are hit both at frame start and mid-frame; a faulty design would overwrite software's buffer or advance past it silently.
- **Enable edge.** Re-enabling with a new base must relocate the ring, and frames offered while disabled must leave everything untouched.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   // Address word layout: used/ownership and wrap flags in the low bits
   localparam int ADDR_USED_BIT = 0;
   localparam int ADDR_WRAP_BIT = 1;

   // Status word layout
   localparam int STAT_LEN_W    = 14;
   localparam int STAT_SOF_BIT  = 14;
   localparam int STAT_EOF_BIT  = 15;

   typedef enum logic {
      ENG_IDLE = 1'b0,
      ENG_FILL = 1'b1
   } eng_state_e;

   // Merge the frame flags and length into a status word, keeping the upper half
   function automatic logic [31:0] fill_status(
      input logic [31:0]           old_word,
      input logic                  sof,
      input logic                  eof,
      input logic [STAT_LEN_W-1:0] len
   );
      return {old_word[31:16], eof, sof, len};
   endfunction

endpackage

// File: rtl/rxd_desc_store.sv
module rxd_desc_store #(
   parameter int DEPTH       = 8,
   parameter int IDXW        = 3,
   parameter bit HOST_RD_REG = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   // engine side
   input  logic            eng_we,
   input  logic [IDXW-1:0] eng_idx,
   input  logic [31:0]     eng_addr_w,
   input  logic [31:0]     eng_stat_w,
   input  logic [IDXW-1:0] cur_idx,
   output logic [31:0]     cur_addr_w,
   output logic [31:0]     cur_stat_w,
   // host side
   input  logic            host_we,
   input  logic            host_sel,
   input  logic [IDXW-1:0] host_idx,
   input  logic [31:0]     host_wdata,
   output logic [31:0]     host_rdata
);

   logic [31:0] addr_arr [DEPTH];
   logic [31:0] stat_arr [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic [31:0] a_q;
      logic [31:0] s_q;
      logic        eng_hit;
      logic        host_hit;

      assign eng_hit  = eng_we  && (eng_idx  == IDXW'(g));
      assign host_hit = host_we && (host_idx == IDXW'(g));

      // engine has priority over the host on the same entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            s_q <= '0;
         end else if (eng_hit) begin
            a_q <= eng_addr_w;
            s_q <= eng_stat_w;
         end else if (host_hit) begin
            if (host_sel) s_q <= host_wdata;
            else          a_q <= host_wdata;
         end
      end

      assign addr_arr[g] = a_q;
      assign stat_arr[g] = s_q;
   end

   assign cur_addr_w = addr_arr[cur_idx];
   assign cur_stat_w = stat_arr[cur_idx];

   logic [31:0] host_sel_word;
   assign host_sel_word = host_sel ? stat_arr[host_idx] : addr_arr[host_idx];

   if (HOST_RD_REG) begin : g_rd_reg
      logic [31:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '0;
         else        rd_q <= host_sel_word;
      end
      assign host_rdata = rd_q;
   end else begin : g_rd_comb
      assign host_rdata = host_sel_word;
   end

endmodule

// File: rtl/rxd_ring_ptr.sv
module rxd_ring_ptr #(
   parameter int DEPTH = 8,
   parameter int IDXW  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_base,
   input  logic [IDXW-1:0] base,
   input  logic            step,
   input  logic            wrap,
   output logic [IDXW-1:0] idx
);

   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

   logic [IDXW-1:0] idx_q;
   logic [IDXW-1:0] next_lin;

   assign next_lin = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         idx_q <= '0;
      else if (load_base) idx_q <= base;
      else if (step)      idx_q <= wrap ? base : next_lin;
   end

   assign idx = idx_q;

endmodule

// File: rtl/rxd_fill_engine.sv
module rxd_fill_engine
   import rxd_pkg::*;
#(
   parameter int BUF_BYTES = 1536
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_en,
   input  logic                  frm_valid,
   input  logic [STAT_LEN_W-1:0] frm_len,
   output logic                  frm_ready,
   output logic                  busy,
   input  logic [31:0]           cur_addr_w,
   input  logic [31:0]           cur_stat_w,
   output logic                  wr_en,
   output logic [31:0]           wr_addr_w,
   output logic [31:0]           wr_stat_w,
   output logic                  step,
   output logic                  wrap,
   output logic                  bna
);

   localparam logic [STAT_LEN_W-1:0] BUF_LEN = STAT_LEN_W'(BUF_BYTES);

   eng_state_e            state_q;
   logic [STAT_LEN_W-1:0] rem_q;
   logic [STAT_LEN_W-1:0] tot_q;
   logic                  first_q;
   logic                  bna_q;

   logic owned;
   logic last_piece;

   assign owned      = cur_addr_w[ADDR_USED_BIT];
   assign last_piece = (rem_q <= BUF_LEN);
   assign busy       = (state_q == ENG_FILL);
   assign frm_ready  = (state_q == ENG_IDLE) && rx_en;

   assign wr_en     = busy && rx_en && !owned;
   assign step      = wr_en;
   assign wrap      = cur_addr_w[ADDR_WRAP_BIT];
   assign wr_addr_w = cur_addr_w | (32'd1 << ADDR_USED_BIT);
   assign wr_stat_w = fill_status(cur_stat_w, first_q, last_piece,
                                  last_piece ? tot_q : BUF_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         rem_q   <= '0;
         tot_q   <= '0;
         first_q <= 1'b0;
         bna_q   <= 1'b0;
      end else begin
         bna_q <= 1'b0;
         unique case (state_q)
            ENG_IDLE: begin
               if (frm_valid && frm_ready) begin
                  tot_q   <= frm_len;
                  rem_q   <= frm_len;
                  first_q <= 1'b1;
                  state_q <= ENG_FILL;
               end
            end
            ENG_FILL: begin
               if (!rx_en) begin
                  state_q <= ENG_IDLE;
               end else if (owned) begin
                  bna_q   <= 1'b1;
                  state_q <= ENG_IDLE;
               end else begin
                  first_q <= 1'b0;
                  rem_q   <= rem_q - BUF_LEN;
                  if (last_piece) state_q <= ENG_IDLE;
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   assign bna = bna_q;

endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
   import rxd_pkg::*;
#(
   parameter int DEPTH       = 8,
   parameter int BUF_BYTES   = 1536,
   parameter bit HOST_RD_REG = 1'b1,
   localparam int IDXW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rx_en,
   input  logic [IDXW-1:0]       ring_base,
   input  logic                  frm_valid,
   input  logic [STAT_LEN_W-1:0] frm_len,
   output logic                  frm_ready,
   output logic                  bna_o,
   output logic [IDXW-1:0]       cur_idx,
   input  logic                  host_we,
   input  logic                  host_sel,
   input  logic [IDXW-1:0]       host_idx,
   input  logic [31:0]           host_wdata,
   output logic [31:0]           host_rdata
);

   // elaboration-time parameter checks
   if (DEPTH < 2) begin : g_chk_depth
      $error("rxd_ring_writer: DEPTH must be at least 2");
   end
   if (BUF_BYTES < 4 || BUF_BYTES > (2**STAT_LEN_W - 1)) begin : g_chk_buf
      $error("rxd_ring_writer: BUF_BYTES must fit the length field");
   end
   if ((BUF_BYTES % 4) != 0) begin : g_chk_align
      $error("rxd_ring_writer: BUF_BYTES must be a multiple of 4");
   end

   logic        rx_en_q;
   logic        load_base;
   logic        busy;
   logic        wr_en;
   logic        step;
   logic        wrap;
   logic [31:0] cur_addr_w;
   logic [31:0] cur_stat_w;
   logic [31:0] wr_addr_w;
   logic [31:0] wr_stat_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rx_en_q <= 1'b0;
      else        rx_en_q <= rx_en;
   end
   assign load_base = rx_en && !rx_en_q;

   rxd_ring_ptr #(.DEPTH(DEPTH), .IDXW(IDXW)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_base (load_base),
      .base      (ring_base),
      .step      (step),
      .wrap      (wrap),
      .idx       (cur_idx)
   );

   rxd_fill_engine #(.BUF_BYTES(BUF_BYTES)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_en      (rx_en),
      .frm_valid  (frm_valid),
      .frm_len    (frm_len),
      .frm_ready  (frm_ready),
      .busy       (busy),
      .cur_addr_w (cur_addr_w),
      .cur_stat_w (cur_stat_w),
      .wr_en      (wr_en),
      .wr_addr_w  (wr_addr_w),
      .wr_stat_w  (wr_stat_w),
      .step       (step),
      .wrap       (wrap),
      .bna        (bna_o)
   );

   rxd_desc_store #(.DEPTH(DEPTH), .IDXW(IDXW), .HOST_RD_REG(HOST_RD_REG)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .eng_we     (wr_en),
      .eng_idx    (cur_idx),
      .eng_addr_w (wr_addr_w),
      .eng_stat_w (wr_stat_w),
      .cur_idx    (cur_idx),
      .cur_addr_w (cur_addr_w),
      .cur_stat_w (cur_stat_w),
      .host_we    (host_we),
      .host_sel   (host_sel),
      .host_idx   (host_idx),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata)
   );

endmodule

// File: rtl/rxd_ring_writer_chk.sv
module rxd_ring_writer_chk #(
   parameter int IDXW = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rx_en,
   input logic [IDXW-1:0] ring_base,
   input logic            frm_valid,
   input logic            frm_ready,
   input logic            bna_o,
   input logic [IDXW-1:0] cur_idx,
   input logic            busy
);

   // R7: disabled receive never offers readiness
   p_ready_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |-> !frm_ready);

   // R7: an enable edge relocates the pointer to the base
   p_base_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_en) |=> (cur_idx == $past(ring_base)));

   // R6: drop flag lasts one cycle only
   p_bna_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bna_o |=> !bna_o);

   // R6: a drop leaves the pointer on the owned descriptor
   p_bna_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bna_o |-> (cur_idx == $past(cur_idx)));

   // R8: an accepted frame makes the block busy and not ready next cycle
   p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && frm_ready) |=> (busy && !frm_ready));

endmodule

bind rxd_ring_writer rxd_ring_writer_chk #(.IDXW(IDXW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_en     (rx_en),
   .ring_base (ring_base),
   .frm_valid (frm_valid),
   .frm_ready (frm_ready),
   .bna_o     (bna_o),
   .cur_idx   (cur_idx),
   .busy      (busy)
);

// File: tb/rxd_ring_writer_tb.sv
module rxd_ring_writer_tb;

   localparam int DEPTH = 8;
   localparam int IDXW  = 3;
   localparam int BUFB  = 1536;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            rx_en = 1'b0;
   logic [IDXW-1:0] ring_base = '0;
   logic            frm_valid = 1'b0;
   logic [13:0]     frm_len = '0;
   logic            frm_ready;
   logic            bna_o;
   logic [IDXW-1:0] cur_idx;
   logic            host_we = 1'b0;
   logic            host_sel = 1'b0;
   logic [IDXW-1:0] host_idx = '0;
   logic [31:0]     host_wdata = '0;
   logic [31:0]     host_rdata;

   int n_checks = 0;
   int n_errors = 0;

   always #2 clk = ~clk;

   rxd_ring_writer #(.DEPTH(DEPTH), .BUF_BYTES(BUFB)) u_dut (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
      .frm_valid(frm_valid), .frm_len(frm_len), .frm_ready(frm_ready),
      .bna_o(bna_o), .cur_idx(cur_idx), .host_we(host_we), .host_sel(host_sel),
      .host_idx(host_idx), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   function automatic logic [31:0] buf_addr(input int i);
      return 32'h2000_0000 + 32'(i) * 32'h600;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic host_wr(input int idx, input bit sel, input logic [31:0] d);
      @(negedge clk);
      host_idx = IDXW'(idx); host_sel = sel; host_wdata = d; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_rd(input int idx, input bit sel, output logic [31:0] d);
      @(negedge clk);
      host_idx = IDXW'(idx); host_sel = sel;
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic send_frame(input int len, output int low_cycles, output bit saw_bna);
      low_cycles = 0; saw_bna = 1'b0;
      @(negedge clk);
      frm_len = 14'(len); frm_valid = 1'b1;
      while (!frm_ready) @(negedge clk);
      @(negedge clk);
      frm_valid = 1'b0;
      while (!frm_ready) begin
         low_cycles++;
         @(negedge clk);
         if (bna_o) saw_bna = 1'b1;
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R9 idx", 32'(cur_idx), 32'd0);
      chk("R9 ready", 32'(frm_ready), 32'd0);
      chk("R9 bna", 32'(bna_o), 32'd0);
      host_rd(3, 1'b0, d); chk("R9 addr word", d, 32'd0);
   endtask

   task automatic t_init_ring;
      logic [31:0] d;
      for (int i = 0; i < DEPTH; i++) begin
         host_wr(i, 1'b0, buf_addr(i) | ((i == 5) ? 32'h2 : 32'h0));
         host_wr(i, 1'b1, 32'hF000_0000);
      end
      host_rd(5, 1'b0, d); chk("R10 host write addr", d, buf_addr(5) | 32'h2);
      host_rd(2, 1'b1, d); chk("R10 host write stat", d, 32'hF000_0000);
      @(negedge clk); rx_en = 1'b1;
      @(negedge clk);
      chk("R7 base on enable", 32'(cur_idx), 32'd0);
   endtask

   task automatic t_single;
      int lc; bit bn; logic [31:0] d;
      send_frame(60, lc, bn);
      chk("R8 single low cycles", 32'(lc), 32'd1);
      host_rd(0, 1'b0, d); chk("R1 used set", d, buf_addr(0) | 32'h1);
      host_rd(0, 1'b1, d); chk("R2 R3 single status", d, 32'hF000_C03C);
      chk("R5 next idx", 32'(cur_idx), 32'd1);
   endtask

   task automatic t_three_piece;
      int lc; bit bn; logic [31:0] d;
      send_frame(4000, lc, bn);
      chk("R8 three low cycles", 32'(lc), 32'd3);
      host_rd(1, 1'b1, d); chk("R4 first piece", d, 32'hF000_4600);
      host_rd(2, 1'b1, d); chk("R4 middle piece", d, 32'hF000_0600);
      host_rd(3, 1'b1, d); chk("R4 last piece total", d, 32'hF000_8FA0);
      chk("R5 idx after three", 32'(cur_idx), 32'd4);
   endtask

   task automatic t_wrap_boundary;
      int lc; bit bn; logic [31:0] d;
      send_frame(BUFB + 1, lc, bn);
      chk("R4 boundary plus one count", 32'(lc), 32'd2);
      host_rd(4, 1'b1, d); chk("R4 first of two", d, 32'hF000_4600);
      host_rd(5, 1'b1, d); chk("R4 last of two", d, 32'hF000_8601);
      host_rd(5, 1'b0, d); chk("R1 wrap kept", d, buf_addr(5) | 32'h3);
      chk("R5 wrap to base", 32'(cur_idx), 32'd0);
   endtask

   task automatic t_owned_first;
      int lc; bit bn; logic [31:0] d;
      send_frame(100, lc, bn);
      chk("R6 bna pulse", 32'(bn), 32'd1);
      chk("R8 drop low cycles", 32'(lc), 32'd1);
      chk("R6 idx held", 32'(cur_idx), 32'd0);
      @(negedge clk);
      chk("R6 bna single cycle", 32'(bna_o), 32'd0);
      host_rd(0, 1'b1, d); chk("R6 status untouched", d, 32'hF000_C03C);
   endtask

   task automatic t_recycle_exact;
      int lc; bit bn; logic [31:0] d;
      host_wr(0, 1'b0, buf_addr(0));
      host_wr(0, 1'b1, 32'hF000_0000);
      send_frame(BUFB, lc, bn);
      chk("R3 exact buffer count", 32'(lc), 32'd1);
      host_rd(0, 1'b1, d); chk("R10 R3 reused exact", d, 32'hF000_C600);
      chk("R5 idx after reuse", 32'(cur_idx), 32'd1);
   endtask

   task automatic t_owned_mid;
      int lc; bit bn; logic [31:0] d;
      host_wr(1, 1'b0, buf_addr(1));
      host_wr(1, 1'b1, 32'hF000_0000);
      send_frame(2000, lc, bn);
      chk("R6 mid bna", 32'(bn), 32'd1);
      chk("R6 mid idx held", 32'(cur_idx), 32'd2);
      host_rd(1, 1'b1, d); chk("R4 mid first piece", d, 32'hF000_4600);
      host_rd(2, 1'b1, d); chk("R6 mid owned untouched", d, 32'hF000_0600);
   endtask

   task automatic t_disable_rebase;
      logic [31:0] d;
      @(negedge clk); rx_en = 1'b0;
      @(negedge clk);
      chk("R7 ready low disabled", 32'(frm_ready), 32'd0);
      frm_len = 14'd64; frm_valid = 1'b1;
      repeat (3) @(negedge clk);
      frm_valid = 1'b0;
      chk("R7 idx still while disabled", 32'(cur_idx), 32'd2);
      host_rd(2, 1'b1, d); chk("R7 no fill while disabled", d, 32'hF000_0600);
      ring_base = 3'd6; rx_en = 1'b1;
      @(negedge clk);
      chk("R7 new base loaded", 32'(cur_idx), 32'd6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_init_ring;
      t_single;
      t_three_piece;
      t_wrap_boundary;
      t_owned_first;
      t_recycle_exact;
      t_owned_mid;
      t_disable_rebase;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule